// File: doc/BRIEF.md
# Floating-Point Exception Vector Classifier

This block sits beside a floating-point unit and decides, one cycle after an instruction is presented, whether a signalling-NaN or operand-error condition on that instruction becomes a trap. If it does, the block names the trap's vector number. It also says whether the trap is taken before the instruction executes or after it completes. The instruction's opclass sets that timing. Opclasses 0 and 2 trap before execution. Opclass 3 traps after completion. All other opclasses never trap on these two conditions.

Each condition has its own enable bit. A condition whose enable is clear causes no trap, and the block then reports that the hardware default result stands in for the trap. This masking holds for every opclass and for every destination format, including integer destinations of opclass 3. When both conditions are enabled and raised together, the signalling-NaN trap wins.

Top module: `fpx_vec_classify`

## Requirements
- R1: A synchronous active-high reset sets exc_req, exc_vector, exc_pre and dflt_used to 0 in the cycle after it is sampled, even if an instruction is presented in that cycle.
- R2: A valid instruction with opclass 0, 2 or 3 and both in_snan and en_snan high produces exc_req=1 and exc_vector=54 at the next clock edge.
- R3: A valid instruction with opclass 0, 2 or 3 and both in_operr and en_operr high, and no enabled signalling NaN, produces exc_req=1 and exc_vector=52 at the next clock edge.
- R4: When both conditions are raised and both are enabled, only vector 54 is issued.
- R5: For opclass 0 or 2, a requested trap carries exc_pre=1, which means pre-instruction.
- R6: For opclass 3, a requested trap carries exc_pre=0, which means post-instruction.
- R7: Opclasses 1, 4, 5, 6 and 7 never raise exc_req. For these opclasses dflt_used stays 0 and exc_vector stays 0.
- R8: A raised condition whose enable is clear causes no trap from that condition and sets dflt_used=1 at the next edge. This holds for opclass 3 as well.
- R9: exc_req is a single-cycle pulse per valid instruction. A cycle with in_valid low returns all outputs to 0 at the next edge. Whenever exc_req is 0, exc_vector and exc_pre read 0.
- R10: When a signalling NaN is masked but an enabled operand error is raised in the same instruction, the outputs are exc_req=1, exc_vector=52 and dflt_used=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction condition flags are valid this cycle |
| in_opclass | input | 3 | Opclass of the instruction |
| in_snan | input | 1 | Signalling-NaN condition raised |
| in_operr | input | 1 | Operand-error condition raised |
| en_snan | input | 1 | Signalling-NaN trap enable |
| en_operr | input | 1 | Operand-error trap enable |
| exc_req | output | 1 | Registered one-cycle trap request |
| exc_vector | output | 8 | Vector number of the requested trap, 0 when none |
| exc_pre | output | 1 | 1 = pre-instruction trap, 0 = post-instruction |
| dflt_used | output | 1 | A raised condition was masked; the hardware default result applies |

## Verification
Two functions can fall in the same cycle: a trap request from one condition, and default-result reporting for the other condition, which is masked. The bench provokes this by raising both flags on an opclass 3 instruction with only the operand-error enable set. It expects vector 52, post-instruction timing and dflt_used high together in the following cycle. The bench also raises both conditions with both enables set, to check that the trap priority leaves dflt_used low.

// File: rtl/fpx_vec_pkg.sv
package fpx_vec_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_SNAN  = 2'd1,
    CAUSE_OPERR = 2'd2
  } cause_e;
endpackage

// File: rtl/fpx_opclass_decode.sv
module fpx_opclass_decode #(
  parameter int OPC_W = 3
) (
  input  logic [OPC_W-1:0] opclass,
  output logic             legal,
  output logic             pre
);
  localparam int NLEGAL = 3;
  localparam logic [OPC_W-1:0] LEGAL_SET [NLEGAL] = '{OPC_W'(0), OPC_W'(2), OPC_W'(3)};
  localparam logic [OPC_W-1:0] POST_OPC = OPC_W'(3);

  logic [NLEGAL-1:0] hit;

  generate
    for (genvar g = 0; g < NLEGAL; g++) begin : g_match
      assign hit[g] = (opclass == LEGAL_SET[g]);
    end
  endgenerate

  always_comb begin
    legal = |hit;
    pre   = legal && (opclass != POST_OPC);
  end
endmodule

// File: rtl/fpx_cause_pick.sv
module fpx_cause_pick
  import fpx_vec_pkg::*;
(
  input  logic   snan,
  input  logic   operr,
  input  logic   en_snan,
  input  logic   en_operr,
  output cause_e cause,
  output logic   masked_any
);
  always_comb begin
    if (snan && en_snan)        cause = CAUSE_SNAN;
    else if (operr && en_operr) cause = CAUSE_OPERR;
    else                        cause = CAUSE_NONE;
    masked_any = (snan && !en_snan) || (operr && !en_operr);
  end
endmodule

// File: rtl/fpx_vec_classify.sv
module fpx_vec_classify
  import fpx_vec_pkg::*;
#(
  parameter int OPC_W     = 3,
  parameter int VEC_W     = 8,
  parameter int SNAN_VEC  = 54,
  parameter int OPERR_VEC = 52
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OPC_W-1:0] in_opclass,
  input  logic             in_snan,
  input  logic             in_operr,
  input  logic             en_snan,
  input  logic             en_operr,
  output logic             exc_req,
  output logic [VEC_W-1:0] exc_vector,
  output logic             exc_pre,
  output logic             dflt_used
);
  localparam logic [VEC_W-1:0] V_SNAN  = VEC_W'(SNAN_VEC);
  localparam logic [VEC_W-1:0] V_OPERR = VEC_W'(OPERR_VEC);

  logic   opc_legal, opc_pre, masked_any, live;
  cause_e cause;

  fpx_opclass_decode #(.OPC_W(OPC_W)) u_dec (
    .opclass (in_opclass),
    .legal   (opc_legal),
    .pre     (opc_pre)
  );

  fpx_cause_pick u_pick (
    .snan       (in_snan),
    .operr      (in_operr),
    .en_snan    (en_snan),
    .en_operr   (en_operr),
    .cause      (cause),
    .masked_any (masked_any)
  );

  assign live = in_valid && opc_legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_req    <= 1'b0;
      exc_vector <= '0;
      exc_pre    <= 1'b0;
      dflt_used  <= 1'b0;
    end else begin
      exc_req    <= live && (cause != CAUSE_NONE);
      exc_pre    <= live && (cause != CAUSE_NONE) && opc_pre;
      dflt_used  <= live && masked_any;
      if (!live)                   exc_vector <= '0;
      else if (cause == CAUSE_SNAN)  exc_vector <= V_SNAN;
      else if (cause == CAUSE_OPERR) exc_vector <= V_OPERR;
      else                           exc_vector <= '0;
    end
  end
endmodule

// File: rtl/fpx_vec_classify_chk.sv
module fpx_vec_classify_chk #(
  parameter int OPC_W     = 3,
  parameter int VEC_W     = 8,
  parameter int SNAN_VEC  = 54,
  parameter int OPERR_VEC = 52
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [OPC_W-1:0] in_opclass,
  input logic             in_snan,
  input logic             in_operr,
  input logic             en_snan,
  input logic             en_operr,
  input logic             exc_req,
  input logic [VEC_W-1:0] exc_vector,
  input logic             exc_pre,
  input logic             dflt_used
);
  logic ok_opc;
  assign ok_opc = (in_opclass == OPC_W'(0)) || (in_opclass == OPC_W'(2)) ||
                  (in_opclass == OPC_W'(3));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!exc_req && exc_vector == '0 && !exc_pre && !dflt_used));

  // R2
  snan_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ok_opc && in_snan && en_snan) |=> (exc_req && exc_vector == VEC_W'(SNAN_VEC)));

  // R3
  operr_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ok_opc && in_operr && en_operr && !(in_snan && en_snan))
      |=> (exc_req && exc_vector == VEC_W'(OPERR_VEC)));

  // R6
  post_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opclass == OPC_W'(3)) |=> !exc_pre);

  // R7
  bad_opclass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ok_opc) |=> (!exc_req && !dflt_used));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!exc_req && !dflt_used));

  // R9
  quiet_fields_chk: assert property (@(posedge clk) disable iff (rst)
    !exc_req |-> (exc_vector == '0 && !exc_pre));
endmodule

bind fpx_vec_classify fpx_vec_classify_chk #(
  .OPC_W(OPC_W), .VEC_W(VEC_W), .SNAN_VEC(SNAN_VEC), .OPERR_VEC(OPERR_VEC)
) u_chk (.*);

// File: tb/fpx_vec_classify_tb.sv
module fpx_vec_classify_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [2:0] in_opclass;
  logic       in_snan, in_operr, en_snan, en_operr;
  logic       exc_req, exc_pre, dflt_used;
  logic [7:0] exc_vector;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fpx_vec_classify u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opclass(in_opclass),
    .in_snan(in_snan), .in_operr(in_operr), .en_snan(en_snan), .en_operr(en_operr),
    .exc_req(exc_req), .exc_vector(exc_vector), .exc_pre(exc_pre), .dflt_used(dflt_used)
  );

  // row: opclass[17:15] snan operr en_snan en_operr [14:11] req[10] vec[9:2] pre[1] dflt[0]
  localparam int NROW = 12;
  localparam logic [17:0] TBL [NROW] = '{
    {3'd0, 4'b1010, 1'b1, 8'd54, 1'b1, 1'b0},  // R2 R5
    {3'd2, 4'b0101, 1'b1, 8'd52, 1'b1, 1'b0},  // R3 R5
    {3'd3, 4'b1010, 1'b1, 8'd54, 1'b0, 1'b0},  // R2 R6
    {3'd3, 4'b0101, 1'b1, 8'd52, 1'b0, 1'b0},  // R3 R6
    {3'd0, 4'b1111, 1'b1, 8'd54, 1'b1, 1'b0},  // R4
    {3'd3, 4'b1101, 1'b1, 8'd52, 1'b0, 1'b1},  // R10
    {3'd2, 4'b1000, 1'b0, 8'd0,  1'b0, 1'b1},  // R8
    {3'd3, 4'b0100, 1'b0, 8'd0,  1'b0, 1'b1},  // R8
    {3'd1, 4'b1010, 1'b0, 8'd0,  1'b0, 1'b0},  // R7
    {3'd7, 4'b1111, 1'b0, 8'd0,  1'b0, 1'b0},  // R7
    {3'd5, 4'b1000, 1'b0, 8'd0,  1'b0, 1'b0},  // R7
    {3'd0, 4'b0000, 1'b0, 8'd0,  1'b0, 1'b0}   // R9
  };
  localparam string TAG [NROW] = '{"R2/R5", "R3/R5", "R2/R6", "R3/R6", "R4", "R10",
                                   "R8", "R8", "R7", "R7", "R7", "R9"};

  task automatic check(input string tag, input logic r, input logic [7:0] v,
                       input logic p, input logic d);
    n_chk++;
    if (exc_req !== r || exc_vector !== v || exc_pre !== p || dflt_used !== d) begin
      n_fail++;
      $display("FAIL %s: got req=%b vec=%0d pre=%b dflt=%b, want req=%b vec=%0d pre=%b dflt=%b",
               tag, exc_req, exc_vector, exc_pre, dflt_used, r, v, p, d);
    end
  endtask

  task automatic drive(input logic vld, input logic [2:0] opc, input logic [3:0] f);
    in_valid   = vld;
    in_opclass = opc;
    {in_snan, in_operr, en_snan, en_operr} = f;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, 3'd0, 4'b0000);
    @(posedge clk); @(negedge clk);
    check("R1", 1'b0, 8'd0, 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NROW; i++) begin
      drive(1'b1, TBL[i][17:15], TBL[i][14:11]);
      @(posedge clk); @(negedge clk);
      check(TAG[i], TBL[i][10], TBL[i][9:2], TBL[i][1], TBL[i][0]);
    end

    // R9: pulse ends when valid drops, even with flags still raised
    drive(1'b1, 3'd2, 4'b1010);
    @(posedge clk); @(negedge clk);
    check("R9", 1'b1, 8'd54, 1'b1, 1'b0);
    drive(1'b0, 3'd2, 4'b1111);
    @(posedge clk); @(negedge clk);
    check("R9", 1'b0, 8'd0, 1'b0, 1'b0);

    // R9: back-to-back valid instructions give fresh results each cycle
    drive(1'b1, 3'd3, 4'b0101);
    @(posedge clk); @(negedge clk);
    check("R9", 1'b1, 8'd52, 1'b0, 1'b0);
    drive(1'b1, 3'd0, 4'b1000);
    @(posedge clk); @(negedge clk);
    check("R9", 1'b0, 8'd0, 1'b0, 1'b1);

    // R1: reset wins over a live trap
    rst = 1'b1;
    drive(1'b1, 3'd0, 4'b1111);
    @(posedge clk); @(negedge clk);
    check("R1", 1'b0, 8'd0, 1'b0, 1'b0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R2", 1'b1, 8'd54, 1'b1, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule